// File: doc/BRIEF.md
# Cascaded DMA request mask unit

This block keeps the request mask for eight DMA channels split across two four-channel controllers. The lower controller serves channels 0 to 3 and the upper controller serves channels 4 to 7. The lower controller reaches the bus through upper channel 4, so masking channel 4 also shuts off every lower channel. Each controller has its own register-side port set:

- a write-all-mask port that loads all four masks in one access,
- a write-single-mask-bit port that sets or clears one channel,
- a master-clear strobe,
- a combinational mask status read.

Hardware can also set a mask. When a channel signals terminal count, its mask is set, unless that channel runs in auto-initialize mode. The block turns the raw DMA request lines into gated request lines for the arbiter. A request passes only when its own mask is clear and, for the lower channels, when channel 4 is unmasked as well.

There is no sequencing here, so the block has no state machine. Its only state is two four-bit mask registers, one per controller. Each register moves to a next value chosen by a fixed priority in every clock:

1. Master clear wins over everything else.
2. Otherwise a write-all load is taken first.
3. A write-single change is applied on top of that result.
4. Terminal-count sets are ORed in last.

Top module: `cascaded_dreq_mask`

## Requirements
- R1: Status bits [7:4] of each controller always read 0. Bits [7:4] of a write-all value are ignored.
- R2: For every channel n, gated request n is 1 only when raw request n is 1 and mask n is 0. A mask bit of 1 blocks the request.
- R3: Reset, and a master-clear strobe on a controller, set all four masks of that controller to 1 (status 8'h0F). A master clear leaves the other controller untouched, and it overrides any write in the same clock.
- R4: A write-all access loads write data bits [3:0] into the controller's masks, with bit n going to local channel n, one clock after the access.
- R5: A write-single access with 2-bit select s and value v sets local mask s to v and leaves the other three masks unchanged. For the upper controller, s maps to channel s+4.
- R6: A terminal-count pulse on channel n sets mask n to 1 one clock later, unless auto-initialize n is 1. The pulse wins over a software clear of the same mask in the same clock.
- R7: While mask 4 (upper local bit 0) is 1, gated requests 0 to 3 are 0 whatever their own masks are. The lower status read is not changed by this.
- R8: The status read shows the mask register contents in the same cycle, including bits set by terminal count. Bit n is channel n for the lower controller and channel n+4 for the upper. Reading has no side effects.
- R9: A write-all and a write-single access in the same clock on one controller are combined: the write-all value is loaded first and the selected bit is then overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_wam_we | input | 1 | Lower controller write-all strobe |
| lo_wam_wdata | input | 8 | Lower controller write-all data |
| lo_wsm_we | input | 1 | Lower controller write-single strobe |
| lo_wsm_sel | input | 2 | Lower controller write-single channel select |
| lo_wsm_set | input | 1 | Lower controller write-single value (1 masks) |
| lo_mclr | input | 1 | Lower controller master clear |
| lo_mask_rd | output | 8 | Lower controller mask status |
| hi_wam_we | input | 1 | Upper controller write-all strobe |
| hi_wam_wdata | input | 8 | Upper controller write-all data |
| hi_wsm_we | input | 1 | Upper controller write-single strobe |
| hi_wsm_sel | input | 2 | Upper controller write-single channel select |
| hi_wsm_set | input | 1 | Upper controller write-single value (1 masks) |
| hi_mclr | input | 1 | Upper controller master clear |
| hi_mask_rd | output | 8 | Upper controller mask status |
| tc_pulse | input | 8 | Per-channel terminal-count pulse |
| autoinit | input | 8 | Per-channel auto-initialize mode flag |
| dreq_in | input | 8 | Raw DMA request lines |
| dreq_out | output | 8 | Gated DMA request lines |

## Verification
The bench builds the block with its default parameters: four channels per controller and an 8-bit register width. These are the only values at which the 2-bit select, the reserved upper nibble and the channel-4 cascade all exist together. With them the bench can reach every same-clock collision: a terminal count against a clear, write-all against write-single, and master clear against a write. It can also check that channel 4 blocks all lower requests while the lower masks themselves stay as they were.

// File: rtl/dmask_pkg.sv
package dmask_pkg;
    localparam int CTRL_COUNT = 2;

    typedef enum logic [0:0] {
        CTRL_LOWER = 1'b0,
        CTRL_UPPER = 1'b1
    } ctrl_id_e;
endpackage

// File: rtl/dmask_bank.sv
module dmask_bank #(
    parameter int CH    = 4,
    parameter int REG_W = 8,
    parameter int SEL_W = $clog2(CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wam_we,
    input  logic [REG_W-1:0] wam_wdata,
    input  logic             wsm_we,
    input  logic [SEL_W-1:0] wsm_sel,
    input  logic             wsm_set,
    input  logic             mclr,
    input  logic [CH-1:0]    tc_pulse,
    input  logic [CH-1:0]    autoinit,
    output logic [CH-1:0]    mask_q,
    output logic [REG_W-1:0] status
);
    logic [CH-1:0] sw_next;
    logic [CH-1:0] tc_hit;
    logic [CH-1:0] mask_d;

    // Priority: master clear, then write-all, then write-single, then TC OR-in
    always_comb begin
        tc_hit  = tc_pulse & ~autoinit;
        sw_next = mask_q;
        if (wam_we)
            sw_next = wam_wdata[CH-1:0];
        if (wsm_we)
            sw_next[wsm_sel] = wsm_set;
        if (mclr)
            mask_d = '1;
        else
            mask_d = sw_next | tc_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else
            mask_q <= mask_d;
    end

    // Reserved upper bits read as zero
    always_comb begin
        status         = '0;
        status[CH-1:0] = mask_q;
    end

    // R6: terminal count outside auto-initialize sets the mask
    a_r6_tc_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit != '0) |=> ((mask_q & $past(tc_hit)) == $past(tc_hit)));

    // R3: master clear masks every channel of this controller
    a_r3_clear_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask_q == '1));

    // R4: a lone write-all loads the low data bits
    a_r4_write_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wam_we && !wsm_we && !mclr && (tc_hit == '0))
        |=> (mask_q == $past(wam_wdata[CH-1:0])));

    // R8: with no write, clear or terminal count the masks hold
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wam_we && !wsm_we && !mclr && (tc_hit == '0)) |=> $stable(mask_q));
endmodule

// File: rtl/dmask_gate.sv
module dmask_gate #(
    parameter int NUM_CH    = 8,
    parameter int LOW_CH    = 4,
    parameter int CASCADE_I = 4
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [NUM_CH-1:0] dreq_in,
    output logic [NUM_CH-1:0] dreq_out
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        if (n < LOW_CH) begin : g_low
            assign dreq_out[n] = dreq_in[n] & ~mask[n] & ~mask[CASCADE_I];
        end else begin : g_high
            assign dreq_out[n] = dreq_in[n] & ~mask[n];
        end
    end
endmodule

// File: rtl/cascaded_dreq_mask.sv
module cascaded_dreq_mask #(
    parameter int CH_PER_CTRL = 4,
    parameter int REG_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lo_wam_we,
    input  logic [REG_W-1:0]       lo_wam_wdata,
    input  logic                   lo_wsm_we,
    input  logic [1:0]             lo_wsm_sel,
    input  logic                   lo_wsm_set,
    input  logic                   lo_mclr,
    output logic [REG_W-1:0]       lo_mask_rd,
    input  logic                   hi_wam_we,
    input  logic [REG_W-1:0]       hi_wam_wdata,
    input  logic                   hi_wsm_we,
    input  logic [1:0]             hi_wsm_sel,
    input  logic                   hi_wsm_set,
    input  logic                   hi_mclr,
    output logic [REG_W-1:0]       hi_mask_rd,
    input  logic [2*CH_PER_CTRL-1:0] tc_pulse,
    input  logic [2*CH_PER_CTRL-1:0] autoinit,
    input  logic [2*CH_PER_CTRL-1:0] dreq_in,
    output logic [2*CH_PER_CTRL-1:0] dreq_out
);
    import dmask_pkg::*;

    localparam int NUM_CH    = CTRL_COUNT * CH_PER_CTRL;
    localparam int SEL_W     = $clog2(CH_PER_CTRL);
    localparam int CASCADE_I = CH_PER_CTRL;

    logic [CTRL_COUNT-1:0]  wam_we_v, wsm_we_v, wsm_set_v, mclr_v;
    logic [REG_W-1:0]       wam_wd_v [CTRL_COUNT];
    logic [SEL_W-1:0]       wsm_sel_v[CTRL_COUNT];
    logic [REG_W-1:0]       status_v [CTRL_COUNT];
    logic [NUM_CH-1:0]      mask_all;

    always_comb begin
        wam_we_v[CTRL_LOWER]  = lo_wam_we;
        wam_we_v[CTRL_UPPER]  = hi_wam_we;
        wam_wd_v[CTRL_LOWER]  = lo_wam_wdata;
        wam_wd_v[CTRL_UPPER]  = hi_wam_wdata;
        wsm_we_v[CTRL_LOWER]  = lo_wsm_we;
        wsm_we_v[CTRL_UPPER]  = hi_wsm_we;
        wsm_sel_v[CTRL_LOWER] = lo_wsm_sel[SEL_W-1:0];
        wsm_sel_v[CTRL_UPPER] = hi_wsm_sel[SEL_W-1:0];
        wsm_set_v[CTRL_LOWER] = lo_wsm_set;
        wsm_set_v[CTRL_UPPER] = hi_wsm_set;
        mclr_v[CTRL_LOWER]    = lo_mclr;
        mclr_v[CTRL_UPPER]    = hi_mclr;
    end

    for (genvar c = 0; c < CTRL_COUNT; c++) begin : g_bank
        dmask_bank #(
            .CH    (CH_PER_CTRL),
            .REG_W (REG_W),
            .SEL_W (SEL_W)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wam_we    (wam_we_v[c]),
            .wam_wdata (wam_wd_v[c]),
            .wsm_we    (wsm_we_v[c]),
            .wsm_sel   (wsm_sel_v[c]),
            .wsm_set   (wsm_set_v[c]),
            .mclr      (mclr_v[c]),
            .tc_pulse  (tc_pulse[c*CH_PER_CTRL +: CH_PER_CTRL]),
            .autoinit  (autoinit[c*CH_PER_CTRL +: CH_PER_CTRL]),
            .mask_q    (mask_all[c*CH_PER_CTRL +: CH_PER_CTRL]),
            .status    (status_v[c])
        );
    end

    assign lo_mask_rd = status_v[CTRL_LOWER];
    assign hi_mask_rd = status_v[CTRL_UPPER];

    dmask_gate #(
        .NUM_CH    (NUM_CH),
        .LOW_CH    (CH_PER_CTRL),
        .CASCADE_I (CASCADE_I)
    ) i_gate (
        .mask     (mask_all),
        .dreq_in  (dreq_in),
        .dreq_out (dreq_out)
    );

    // R7: masked cascade channel blocks every lower request
    a_r7_cascade_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hi_mask_rd[0] |-> (dreq_out[CH_PER_CTRL-1:0] == '0));

    // R2: no masked channel ever presents a request
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((dreq_out & {hi_mask_rd[CH_PER_CTRL-1:0], lo_mask_rd[CH_PER_CTRL-1:0]}) == '0));

    // R1: reserved status bits stay zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_mask_rd[REG_W-1:CH_PER_CTRL] == '0) && (hi_mask_rd[REG_W-1:CH_PER_CTRL] == '0));
endmodule

// File: tb/test_cascaded_dreq_mask.sv
module test_cascaded_dreq_mask;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_wam_we = 0, lo_wsm_we = 0, lo_wsm_set = 0, lo_mclr = 0;
    logic [7:0] lo_wam_wdata = 0;
    logic [1:0] lo_wsm_sel = 0;
    logic       hi_wam_we = 0, hi_wsm_we = 0, hi_wsm_set = 0, hi_mclr = 0;
    logic [7:0] hi_wam_wdata = 0;
    logic [1:0] hi_wsm_sel = 0;
    logic [7:0] tc_pulse = 0, autoinit = 0, dreq_in = 0;
    logic [7:0] lo_mask_rd, hi_mask_rd, dreq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cascaded_dreq_mask i_cascaded_dreq_mask (
        .clk(clk), .rst_n(rst_n),
        .lo_wam_we(lo_wam_we), .lo_wam_wdata(lo_wam_wdata),
        .lo_wsm_we(lo_wsm_we), .lo_wsm_sel(lo_wsm_sel), .lo_wsm_set(lo_wsm_set),
        .lo_mclr(lo_mclr), .lo_mask_rd(lo_mask_rd),
        .hi_wam_we(hi_wam_we), .hi_wam_wdata(hi_wam_wdata),
        .hi_wsm_we(hi_wsm_we), .hi_wsm_sel(hi_wsm_sel), .hi_wsm_set(hi_wsm_set),
        .hi_mclr(hi_mclr), .hi_mask_rd(hi_mask_rd),
        .tc_pulse(tc_pulse), .autoinit(autoinit),
        .dreq_in(dreq_in), .dreq_out(dreq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply staged inputs over one edge, release strobes, sample mid-cycle
    task automatic step();
        @(posedge clk);
        #1;
        lo_wam_we = 0; lo_wsm_we = 0; lo_mclr = 0;
        hi_wam_we = 0; hi_wsm_we = 0; hi_mclr = 0;
        tc_pulse = 0;
    endtask

    task automatic wam(input bit hi, input logic [7:0] d);
        if (hi) begin hi_wam_we = 1; hi_wam_wdata = d; end
        else    begin lo_wam_we = 1; lo_wam_wdata = d; end
    endtask

    task automatic wsm(input bit hi, input logic [1:0] s, input bit v);
        if (hi) begin hi_wsm_we = 1; hi_wsm_sel = s; hi_wsm_set = v; end
        else    begin lo_wsm_we = 1; lo_wsm_sel = s; lo_wsm_set = v; end
    endtask

    task automatic t_reset();
        dreq_in = 8'hFF; #1;
        chk("R3 reset lo", lo_mask_rd, 8'h0F);
        chk("R3 reset hi", hi_mask_rd, 8'h0F);
        chk("R2 reset gated", dreq_out, 8'h00);
    endtask

    task automatic t_write_all();
        wam(0, 8'hF0); wam(1, 8'h00); step();
        chk("R1 R4 reserved bits ignored lo", lo_mask_rd, 8'h00);
        chk("R4 hi cleared", hi_mask_rd, 8'h00);
        dreq_in = 8'hFF; #1; chk("R2 all open", dreq_out, 8'hFF);
        dreq_in = 8'hA5; #1; chk("R2 pattern A5", dreq_out, 8'hA5);
        wam(0, 8'h05); step();
        dreq_in = 8'hFF; #1;
        chk("R4 lo 05", lo_mask_rd, 8'h05);
        chk("R2 partial mask", dreq_out, 8'hFA);
    endtask

    task automatic t_single_and_cascade();
        wsm(1, 2'd0, 1); step();
        chk("R5 hi sel0 set", hi_mask_rd, 8'h01);
        chk("R7 cascade blocks low", dreq_out, 8'hE0);
        chk("R7 lo status untouched", lo_mask_rd, 8'h05);
        wsm(1, 2'd0, 0); step();
        chk("R7 cascade reopened", dreq_out, 8'hFA);
        wsm(0, 2'd1, 1); step();
        chk("R5 lo sel1 set", lo_mask_rd, 8'h07);
        wsm(1, 2'd3, 1); step();
        chk("R5 hi sel3 maps ch7", dreq_out, 8'h78);
    endtask

    task automatic t_tc();
        wam(0, 8'h00); wam(1, 8'h00); step();
        tc_pulse = 8'h40; step();
        chk("R6 tc ch6", hi_mask_rd, 8'h04);
        chk("R8 status shows tc bit", dreq_out, 8'hBF);
        autoinit = 8'h04; tc_pulse = 8'h04; step();
        chk("R6 autoinit suppresses", lo_mask_rd, 8'h00);
        autoinit = 8'h00;
        tc_pulse = 8'h08; wsm(0, 2'd3, 0); step();
        chk("R6 tc wins over clear", lo_mask_rd, 8'h08);
        tc_pulse = 8'h02; wam(0, 8'h00); step();
        chk("R6 tc wins over write-all", lo_mask_rd, 8'h02);
    endtask

    task automatic t_clear_combine();
        hi_mclr = 1; step();
        chk("R3 mclr hi", hi_mask_rd, 8'h0F);
        chk("R3 mclr leaves lo", lo_mask_rd, 8'h02);
        wam(0, 8'h0F); wsm(0, 2'd0, 0); step();
        chk("R9 write-all then single", lo_mask_rd, 8'h0E);
        lo_mclr = 1; wam(0, 8'h00); step();
        chk("R3 mclr overrides write", lo_mask_rd, 8'h0F);
        wam(0, 8'h09); step();
        step(); step();
        chk("R8 repeated reads no side effect", lo_mask_rd, 8'h09);
        chk("R8 read stable", lo_mask_rd, 8'h09);
    endtask

    initial begin
        #12; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_all();
        t_single_and_cascade();
        t_tc();
        t_clear_combine();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule